// File: doc/BRIEF.md
# PCI Bus-Master Burst DMA Engine

This block is the 32-bit PCI initiator used by a network controller to move blocks of words between its local FIFO and host memory. A request supplies a word-aligned host address, a word count and a direction. It also says whether the target is a control structure or a data structure. The engine asks the arbiter for the bus and drives the address phase with the right memory command. It then runs zero-wait-state bursts with every byte enabled. Data goes into the FIFO on reads and comes from the FIFO on writes.

A transfer can need several bursts. Each burst is sized when the bus is granted. Its length is the smallest of the words still owed, the free space or stored words in the FIFO, and a programmable per-arbitration limit. There is one such limit for the transmit direction (host reads) and one for the receive direction (host writes). Some terminations end a burst but can be recovered: backoff, target retry and target disconnect. After one of these the engine requests the bus again and resumes at the exact word where the previous burst stopped.

A target abort and a master abort end the whole transfer. They are recorded in a 16-bit status word, at bit 12 and bit 13 respectively. An external error indication lets the current burst run to its end, and then the transfer finishes flagged as failed. Parity generation, configuration space and the arbiter itself live elsewhere.

Top module: `pci_burst_master`

## Requirements
- R1: The address-phase command on `cbe_n` is 0110 for a host read, 0111 for a write to a control structure, 1111 for a write to a data structure when `cfg_mwi_en` is 1, and 0111 for a data-structure write when it is 0. During data phases `cbe_n` is 0000 (all bytes enabled).
- R2: In a host read, `irdy_n` stays low on every clock while `frame_n` is low after the address phase. Each clock with `trdy_n` low pushes `ad_in` into the FIFO, in address order.
- R3: In a host write, `ad_out` carries the FIFO head from the first data phase onward. A FIFO word is popped only on a clock where `trdy_n` is low, so target wait states stretch the phase without losing or repeating data.
- R4: The length of each burst is at most the words still owed, at most `fifo_avail` sampled at grant, and at most `cfg_tx_max` for reads or `cfg_rx_max` for writes, where 0 means no limit. A transfer longer than the limit is split over several bursts.
- R5: `frame_n` goes high while `irdy_n` is still low for the final data phase. `irdy_n` returns high no earlier than `frame_n`.
- R6: Backoff applies when `lat_expired` is 1 and `gnt_n` is high during a burst. The engine then makes the next phase the final one and later re-requests the bus for the remaining words.
- R7: After a target retry or disconnect (`stop_n` low with `devsel_n` low), the engine ends the burst and restarts at the next untransferred address. The address and remaining count change only on clocks with both `irdy_n` and `trdy_n` low, so no word is lost or duplicated.
- R8: Target abort is `stop_n` low with `devsel_n` high. It sets `status` bit 12, completes the request with `done_err`=1, and never starts another address phase for that request.
- R9: If `devsel_n` is not seen low during the first 5 clocks after the address phase, the engine releases `frame_n` and `irdy_n` together. It sets `status` bit 13 and completes with `done_err`=1.
- R10: A pulse on `err_in` during a transfer lets the current burst run to its normal end. The request then completes with `done_err`=1 and no further burst.
- R11: After reset, `frame_n`, `irdy_n` and `req_n` are high, both output enables are low, `status` is 0 and `req_ready` is 1. `status` clears when a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start a transfer (taken when `req_ready` is 1) |
| req_ready | output | 1 | Engine idle, able to take a request |
| req_write | input | 1 | 1: FIFO to host memory, 0: host memory to FIFO |
| req_ctrl | input | 1 | 1: target is a control structure |
| req_addr | input | 32 | Host byte address, word aligned |
| req_words | input | CW | Number of 32-bit words |
| cfg_mwi_en | input | 1 | Allow Memory Write and Invalidate for data-structure writes |
| cfg_tx_max | input | MW | Per-arbitration word limit for reads, 0 = none |
| cfg_rx_max | input | MW | Per-arbitration word limit for writes, 0 = none |
| fifo_avail | input | CW | Words stored (writes) or free slots (reads) |
| fifo_pop | output | 1 | Consume FIFO head |
| fifo_rdata | input | 32 | FIFO head word |
| fifo_push | output | 1 | Store `fifo_wdata` |
| fifo_wdata | output | 32 | Word read from host |
| req_n | output | 1 | Bus request to the arbiter |
| gnt_n | input | 1 | Bus grant |
| lat_expired | input | 1 | Latency timer has run out |
| ad_out | output | 32 | Address/data driven |
| ad_oe | output | 1 | Enable for `ad_out` |
| ad_in | input | 32 | Address/data sampled |
| cbe_n | output | 4 | Command / byte enables |
| cbe_oe | output | 1 | Enable for `cbe_n` |
| frame_n | output | 1 | Cycle frame |
| irdy_n | output | 1 | Initiator ready |
| devsel_n | input | 1 | Target selected |
| trdy_n | input | 1 | Target ready |
| stop_n | input | 1 | Target stop request |
| err_in | input | 1 | Parity or system error seen |
| done | output | 1 | One-clock completion pulse |
| done_err | output | 1 | Completion was an abort or error |
| status | output | 16 | Bit 12 target abort, bit 13 master abort |

## Verification
The bench builds the engine with CW=12, MW=8 and a 5-clock select window. It programs small burst limits (3 and 4 words) and a FIFO capped at 3 words, so transfers of 7 to 10 words split into two or three bursts within a few dozen clocks. The opposite direction's limit is always set to 1, so a swap of the transmit and receive limits would change the burst counts. A behavioural target retries, disconnects after a chosen word, inserts waits, aborts or stays silent on the first attempt, and the data that lands on each side is compared word by word.

// File: rtl/pci_burst_master.sv
`timescale 1ns/1ps
module pci_burst_master #(
  parameter int CW      = 12,
  parameter int MW      = 8,
  parameter int MA_CLKS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_ctrl,
  input  logic [31:0]   req_addr,
  input  logic [CW-1:0] req_words,
  input  logic          cfg_mwi_en,
  input  logic [MW-1:0] cfg_tx_max,
  input  logic [MW-1:0] cfg_rx_max,
  input  logic [CW-1:0] fifo_avail,
  output logic          fifo_pop,
  input  logic [31:0]   fifo_rdata,
  output logic          fifo_push,
  output logic [31:0]   fifo_wdata,
  output logic          req_n,
  input  logic          gnt_n,
  input  logic          lat_expired,
  output logic [31:0]   ad_out,
  output logic          ad_oe,
  input  logic [31:0]   ad_in,
  output logic [3:0]    cbe_n,
  output logic          cbe_oe,
  output logic          frame_n,
  output logic          irdy_n,
  input  logic          devsel_n,
  input  logic          trdy_n,
  input  logic          stop_n,
  input  logic          err_in,
  output logic          done,
  output logic          done_err,
  output logic [15:0]   status
);
  localparam int MAW = $clog2(MA_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ADDR, S_DATA, S_TURN} st_t;
  st_t state;

  logic [31:0]    addr_q;
  logic [CW-1:0]  rem_q, left_q;
  logic           wr_q, ctrl_q, dsel_seen, fatal, err_pend, stat_ta, stat_ma;
  logic [3:0]     cmd_q;
  logic [MAW-1:0] ma_cnt;

  logic [MW-1:0]  dir_max;
  logic [CW-1:0]  lim_max, blen_a, blen;
  logic           xfer, tabort, mabort, backoff;

  assign dir_max = wr_q ? cfg_rx_max : cfg_tx_max;
  assign lim_max = (dir_max == '0) ? rem_q : CW'(dir_max);
  assign blen_a  = (rem_q < lim_max) ? rem_q : lim_max;
  assign blen    = (blen_a < fifo_avail) ? blen_a : fifo_avail;

  assign xfer    = (state == S_DATA) && !irdy_n && !trdy_n;
  assign tabort  = (state == S_DATA) && !stop_n && devsel_n;
  assign mabort  = (state == S_DATA) && !dsel_seen && devsel_n &&
                   (ma_cnt == MAW'(MA_CLKS - 1));
  assign backoff = lat_expired && gnt_n;

  assign req_ready  = (state == S_IDLE);
  assign req_n      = !((state == S_REQ) && (fifo_avail != '0) && !err_pend && (rem_q != '0));
  assign ad_oe      = (state == S_ADDR) || ((state == S_DATA) && wr_q);
  assign ad_out     = (state == S_ADDR) ? addr_q : fifo_rdata;
  assign cbe_oe     = (state == S_ADDR) || (state == S_DATA);
  assign cbe_n      = (state == S_ADDR) ? cmd_q : 4'b0000;
  assign fifo_pop   = xfer && wr_q;
  assign fifo_push  = xfer && !wr_q;
  assign fifo_wdata = ad_in;
  assign status     = {2'b00, stat_ma, stat_ta, 12'h000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      frame_n   <= 1'b1;
      irdy_n    <= 1'b1;
      addr_q    <= '0;
      rem_q     <= '0;
      left_q    <= '0;
      wr_q      <= 1'b0;
      ctrl_q    <= 1'b0;
      cmd_q     <= 4'b0110;
      dsel_seen <= 1'b0;
      ma_cnt    <= '0;
      fatal     <= 1'b0;
      err_pend  <= 1'b0;
      stat_ta   <= 1'b0;
      stat_ma   <= 1'b0;
      done      <= 1'b0;
      done_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (err_in && state != S_IDLE) err_pend <= 1'b1;
      case (state)
        S_IDLE: if (req_valid) begin
          state    <= S_REQ;
          addr_q   <= {req_addr[31:2], 2'b00};
          rem_q    <= req_words;
          wr_q     <= req_write;
          ctrl_q   <= req_ctrl;
          cmd_q    <= !req_write ? 4'b0110 :
                      (!req_ctrl && cfg_mwi_en) ? 4'b1111 : 4'b0111;
          fatal    <= 1'b0;
          err_pend <= 1'b0;
          stat_ta  <= 1'b0;
          stat_ma  <= 1'b0;
          done_err <= 1'b0;
        end
        S_REQ: if (err_pend || rem_q == '0) begin
          state    <= S_IDLE;
          done     <= 1'b1;
          done_err <= err_pend;
        end else if (!gnt_n && fifo_avail != '0) begin
          state   <= S_ADDR;
          frame_n <= 1'b0;
          left_q  <= blen;
        end
        S_ADDR: begin
          state     <= S_DATA;
          irdy_n    <= 1'b0;
          frame_n   <= (left_q == CW'(1));
          dsel_seen <= 1'b0;
          ma_cnt    <= '0;
        end
        S_DATA: begin
          if (!devsel_n) dsel_seen <= 1'b1;
          else if (!dsel_seen) ma_cnt <= ma_cnt + 1'b1;
          if (xfer) begin
            addr_q <= addr_q + 32'd4;
            rem_q  <= rem_q - 1'b1;
            left_q <= left_q - 1'b1;
          end
          if (mabort) begin
            frame_n <= 1'b1;
            irdy_n  <= 1'b1;
            stat_ma <= 1'b1;
            fatal   <= 1'b1;
            state   <= S_TURN;
          end else if (tabort) begin
            frame_n <= 1'b1;
            irdy_n  <= 1'b1;
            stat_ta <= 1'b1;
            fatal   <= 1'b1;
            state   <= S_TURN;
          end else if (frame_n) begin
            if (xfer || !stop_n) begin
              irdy_n <= 1'b1;
              state  <= S_TURN;
            end
          end else if (!stop_n || backoff || (xfer && left_q == CW'(2))) begin
            frame_n <= 1'b1;
          end
        end
        S_TURN: if (fatal || err_pend || rem_q == '0) begin
          state    <= S_IDLE;
          done     <= 1'b1;
          done_err <= fatal || err_pend;
        end else begin
          state <= S_REQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_CTRL_WRITE_MW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && wr_q && ctrl_q) |-> cbe_n == 4'b0111); // R1
  AST_IRDY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && !frame_n) |-> !irdy_n); // R2
  AST_FRAME_BEFORE_IRDY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irdy_n) |-> frame_n); // R5
  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR) |-> (left_q <= rem_q && left_q != '0)); // R4
  AST_HOLD_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && trdy_n) |=> $stable(rem_q)); // R7
  AST_TA_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ta |-> state != S_ADDR); // R8
  AST_MA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && !dsel_seen) |-> ma_cnt < MAW'(MA_CLKS)); // R9
  AST_ERR_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pend && state == S_TURN) |=> state == S_IDLE); // R10
endmodule

// File: tb/sim_pci_burst_master.sv
`timescale 1ns/1ps
module sim_pci_burst_master;
  localparam int CW = 12;
  localparam int MW = 8;

  typedef struct packed {
    logic        wr;
    logic        ctrl;
    logic        mwi;
    logic [3:0]  mode;
    logic [11:0] words;
    logic [7:0]  maxc;
    logic [11:0] cap;
    logic [7:0]  k;
    logic [3:0]  ecmd;
    logic [7:0]  ebur;
    logic [11:0] exf;
    logic [15:0] ests;
    logic        eerr;
  } vec_t;

  // modes: 0 normal, 1 waits, 2 retry, 3 disconnect, 4 target abort, 5 silent, 6 backoff, 7 error
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,4'd0,12'd8, 8'd0,12'd100,8'd0,4'h6,8'd1,12'd8, 16'h0000,1'b0}, // R2
    '{1'b1,1'b0,1'b1,4'd0,12'd8, 8'd0,12'd100,8'd0,4'hF,8'd1,12'd8, 16'h0000,1'b0}, // R1 R3
    '{1'b1,1'b1,1'b1,4'd0,12'd4, 8'd0,12'd100,8'd0,4'h7,8'd1,12'd4, 16'h0000,1'b0}, // R1
    '{1'b1,1'b0,1'b0,4'd1,12'd5, 8'd0,12'd100,8'd0,4'h7,8'd1,12'd5, 16'h0000,1'b0}, // R3 waits
    '{1'b0,1'b0,1'b0,4'd0,12'd10,8'd4,12'd100,8'd0,4'h6,8'd3,12'd10,16'h0000,1'b0}, // R4 tx limit
    '{1'b1,1'b0,1'b1,4'd0,12'd9, 8'd3,12'd100,8'd0,4'hF,8'd3,12'd9, 16'h0000,1'b0}, // R4 rx limit
    '{1'b1,1'b0,1'b1,4'd0,12'd7, 8'd0,12'd3,  8'd0,4'hF,8'd3,12'd7, 16'h0000,1'b0}, // R4 fifo
    '{1'b0,1'b0,1'b0,4'd0,12'd1, 8'd0,12'd100,8'd0,4'h6,8'd1,12'd1, 16'h0000,1'b0}, // R5 single
    '{1'b0,1'b0,1'b0,4'd2,12'd6, 8'd0,12'd100,8'd0,4'h6,8'd2,12'd6, 16'h0000,1'b0}, // R7 retry
    '{1'b1,1'b0,1'b1,4'd3,12'd8, 8'd0,12'd100,8'd3,4'hF,8'd2,12'd8, 16'h0000,1'b0}, // R7 disconnect
    '{1'b0,1'b0,1'b0,4'd6,12'd8, 8'd0,12'd100,8'd0,4'h6,8'd2,12'd8, 16'h0000,1'b0}, // R6 backoff
    '{1'b0,1'b0,1'b0,4'd4,12'd6, 8'd0,12'd100,8'd0,4'h6,8'd1,12'd0, 16'h1000,1'b1}, // R8
    '{1'b1,1'b0,1'b1,4'd5,12'd4, 8'd0,12'd100,8'd0,4'hF,8'd1,12'd0, 16'h2000,1'b1}, // R9
    '{1'b1,1'b0,1'b1,4'd7,12'd8, 8'd4,12'd100,8'd0,4'hF,8'd1,12'd4, 16'h0000,1'b1}  // R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, req_ctrl = 1'b0, cfg_mwi_en = 1'b0;
  logic [31:0]   req_addr = '0;
  logic [CW-1:0] req_words = '0;
  logic [MW-1:0] cfg_tx_max = '0, cfg_rx_max = '0;
  logic [CW-1:0] fifo_avail = '0;
  logic [31:0]   fifo_rdata = '0, ad_in = '0;
  logic          gnt_n = 1'b1, lat_expired = 1'b0, devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1, err_in = 1'b0;
  logic          req_ready, fifo_pop, fifo_push, req_n, ad_oe, cbe_oe, frame_n, irdy_n, done, done_err;
  logic [31:0]   fifo_wdata, ad_out;
  logic [3:0]    cbe_n;
  logic [15:0]   status;

  pci_burst_master #(.CW(CW), .MW(MW), .MA_CLKS(5)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_ctrl, .req_addr, .req_words,
    .cfg_mwi_en, .cfg_tx_max, .cfg_rx_max, .fifo_avail, .fifo_pop, .fifo_rdata,
    .fifo_push, .fifo_wdata, .req_n, .gnt_n, .lat_expired, .ad_out, .ad_oe, .ad_in,
    .cbe_n, .cbe_oe, .frame_n, .irdy_n, .devsel_n, .trdy_n, .stop_n, .err_in,
    .done, .done_err, .status);

  int total = 0, bad = 0;
  logic clr = 1'b1;
  vec_t cv = '0;

  // target and FIFO model state, written only at the rising edge
  logic        t_act, fprev, iprev;
  logic [9:0]  t_addr;
  int          t_dcyc, t_bxf, bursts, xf_total, max_bxf, rd_idx, rx_idx, mon_bad;
  logic [3:0]  first_cmd;
  logic [31:0] rx   [64];
  logic [31:0] wmem [1024];

  always @(posedge clk) begin
    if (clr) begin
      t_act <= 1'b0; fprev <= 1'b1; iprev <= 1'b1; t_addr <= '0;
      t_dcyc <= 0; t_bxf <= 0; bursts <= 0; xf_total <= 0; max_bxf <= 0;
      rd_idx <= 0; rx_idx <= 0; mon_bad <= 0; first_cmd <= '0;
    end else begin
      fprev <= frame_n;
      iprev <= irdy_n;
      if (fifo_pop) rd_idx <= rd_idx + 1;
      if (fifo_push) begin rx[rx_idx[5:0]] <= fifo_wdata; rx_idx <= rx_idx + 1; end
      if (!irdy_n && cbe_n != 4'b0000) mon_bad <= mon_bad + 1;          // R1
      if (!frame_n && irdy_n && !iprev) mon_bad <= mon_bad + 1;         // R5
      if (!frame_n && fprev && irdy_n) begin
        bursts <= bursts + 1;
        if (bursts == 0) first_cmd <= cbe_n;
        t_addr <= ad_out[11:2];
        t_act <= 1'b1; t_dcyc <= 0; t_bxf <= 0;
      end else if (t_act) begin
        t_dcyc <= t_dcyc + 1;
        if (!frame_n && irdy_n) mon_bad <= mon_bad + 1;                // R2
        if (!irdy_n && !trdy_n) begin
          if (cv.wr) wmem[t_addr] <= ad_out;
          t_addr <= t_addr + 1'b1;
          t_bxf <= t_bxf + 1;
          xf_total <= xf_total + 1;
          if (t_bxf + 1 > max_bxf) max_bxf <= t_bxf + 1;
        end
        if (frame_n && irdy_n) t_act <= 1'b0;
      end
    end
  end

  // drive all target-side inputs half a clock after the edge
  always @(negedge clk) begin
    int n, rem;
    logic a0;
    gnt_n = req_n;
    lat_expired = 1'b0;
    err_in = 1'b0;
    rem = int'(cv.words) - rd_idx;
    fifo_avail = cv.wr ? CW'((rem < int'(cv.cap)) ? rem : int'(cv.cap)) : cv.cap;
    fifo_rdata = 32'hA000_0000 + rd_idx;
    ad_in = 32'h5000_0000 + {22'd0, t_addr};
    n = t_dcyc + 1;
    a0 = (bursts == 1);
    devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
    if (t_act && !(frame_n && irdy_n)) begin
      devsel_n = 1'b0; trdy_n = 1'b0;
      case (cv.mode)
        4'd1: trdy_n = n[0];
        4'd2: if (a0) begin trdy_n = 1'b1; stop_n = 1'b0; end
        4'd3: if (a0) begin
          if (t_bxf == int'(cv.k) - 1) stop_n = 1'b0;
          else if (t_bxf >= int'(cv.k)) begin trdy_n = 1'b1; stop_n = 1'b0; end
        end
        4'd4: if (n == 1) trdy_n = 1'b1;
              else begin devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b0; end
        4'd5: begin devsel_n = 1'b1; trdy_n = 1'b1; end
        4'd6: lat_expired = a0 && t_bxf >= 2;
        4'd7: err_in = a0 && t_bxf == 1;
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input int i);
    vec_t v;
    int base, cnt, lim;
    string rq;
    v = VEC[i];
    rq = (v.mode == 4'd2 || v.mode == 4'd3) ? "R7" : (v.mode == 4'd4) ? "R8" :
         (v.mode == 4'd5) ? "R9" : (v.mode == 4'd6) ? "R6" : (v.mode == 4'd7) ? "R10" : "R4";
    base = 64 * i;
    @(negedge clk);
    clr = 1'b1; cv = v;
    @(negedge clk);
    clr = 1'b0;
    req_valid = 1'b1; req_write = v.wr; req_ctrl = v.ctrl; cfg_mwi_en = v.mwi;
    req_addr = 32'(base * 4); req_words = v.words;
    cfg_tx_max = v.wr ? 8'd1 : v.maxc;
    cfg_rx_max = v.wr ? v.maxc : 8'd1;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0;
    while (!done && cnt < 3000) begin @(negedge clk); cnt++; end
    chk(done == 1'b1, rq, $sformatf("vec%0d completion", i), int'(done), 1);
    chk(done_err == v.eerr, rq, $sformatf("vec%0d done_err", i), int'(done_err), int'(v.eerr));
    chk(status == v.ests, rq, $sformatf("vec%0d status", i), int'(status), int'(v.ests));
    chk(first_cmd == v.ecmd, "R1", $sformatf("vec%0d command", i), int'(first_cmd), int'(v.ecmd));
    chk(bursts == int'(v.ebur), rq, $sformatf("vec%0d bursts", i), bursts, int'(v.ebur));
    chk(xf_total == int'(v.exf), rq, $sformatf("vec%0d transfers", i), xf_total, int'(v.exf));
    lim = (v.maxc != 0) ? int'(v.maxc) : int'(v.words);
    if (int'(v.cap) < lim) lim = int'(v.cap);
    chk(max_bxf <= lim, "R4", $sformatf("vec%0d longest burst", i), max_bxf, lim);
    chk(mon_bad == 0, "R2", $sformatf("vec%0d bus protocol", i), mon_bad, 0);
    for (int j = 0; j < int'(v.exf); j++) begin
      if (v.wr) chk(wmem[base + j] == 32'hA000_0000 + j, "R3", $sformatf("vec%0d host word %0d", i, j),
                    int'(wmem[base + j]), int'(32'hA000_0000 + j));
      else      chk(rx[j] == 32'h5000_0000 + base + j, "R2", $sformatf("vec%0d fifo word %0d", i, j),
                    int'(rx[j]), int'(32'h5000_0000 + base + j));
    end
    chk(req_ready == 1'b1, "R11", $sformatf("vec%0d ready after done", i), int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_n == 1'b1, "R11", "reset frame_n", int'(frame_n), 1);
    chk(irdy_n == 1'b1, "R11", "reset irdy_n", int'(irdy_n), 1);
    chk(req_n == 1'b1, "R11", "reset req_n", int'(req_n), 1);
    chk(ad_oe == 1'b0 && cbe_oe == 1'b0, "R11", "reset enables", int'({ad_oe, cbe_oe}), 0);
    chk(status == 16'h0, "R11", "reset status", int'(status), 0);
    chk(req_ready == 1'b1, "R11", "reset ready", int'(req_ready), 1);
    for (int i = 0; i < NV; i++) run(i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL R11 watchdog: got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule